// File: doc/BRIEF.md
# Self-Programming Control and Status Register

This block holds the control and status register that software uses to reprogram on-chip program memory. Software first arms an operation by writing the operation enable bit together with exactly one command bit: page erase, page write, lock-bit set or busy-clear. It then pulses `op_start` with the target address. A single down-counter limits how long an armed command waits for its start. The same counter also stands in for the flash cells by timing a fixed-length operation that ends in a one-cycle `op_done` pulse.

The program memory is split at a fixed boundary address. Addresses below `RWW_LIMIT` form the read-while-write region, and addresses at or above it form the no-read-while-write region. An erase or write that targets the read-while-write region leaves the CPU running. It sets a sticky busy flag that blocks reads of that region until software runs a busy-clear command. An erase or write that targets the other region halts the CPU for the whole operation and leaves the busy flag unchanged. A ready interrupt is requested whenever the interrupt enable bit and the global interrupt enable are both set and the operation enable bit reads 0.

The sequencer has three states:
- IDLE: nothing is armed.
- ARMED: a command waits for its start.
- RUN: an erase or write is in progress.

Its transitions are:
- IDLE→ARMED, on a valid arming write.
- ARMED→RUN, on a start with erase or write.
- ARMED→IDLE, on a start with lock-set or busy-clear, which completes at once.
- ARMED→IDLE, on expiry of the arming window.
- RUN→IDLE, when the operation count ends.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset, `csr_rdata` reads 0x00 and `cpu_halt`, `spm_irq`, `op_done` and `rww_rd_block` are all 0.
- R2: The register layout is bit 7 interrupt enable, bit 6 busy, bit 5 reserved, bit 4 busy-clear, bit 3 lock-set, bit 2 page write, bit 1 page erase and bit 0 operation enable. Bits 6 and 5 are read-only, so writing them has no effect. Bit 7 takes the written value on every write.
- R3: In IDLE, a write with bit 0 set and exactly one of bits 4..1 set sets bit 0 and that command bit from the next cycle. A write with bit 0 clear, with no command bit, or with more than one command bit leaves bits 4..0 at 0.
- R4: If `op_start` is not seen, bit 0 reads 1 for exactly `ARM_WIN` cycles after the arming write. Bits 4..0 then read 0.
- R5: Starting an erase or write with `op_addr` < `RWW_LIMIT` sets the busy bit from the next cycle and does not halt the CPU. `op_done` is high in the last of `OP_CYCLES` run cycles. Bits 4..0 then read 0 and the busy bit stays 1.
- R6: Starting an erase or write with `op_addr` >= `RWW_LIMIT` drives `cpu_halt` high for exactly `OP_CYCLES` cycles, starting the cycle after the start. The busy bit is not changed.
- R7: `rww_rd_block` is 1 exactly when the busy bit is 1 and `rd_addr` < `RWW_LIMIT`.
- R8: A start while busy-clear is armed clears the busy bit from the next cycle. `op_done` is high in the start cycle.
- R9: During RUN, writes do not change bits 4..0, so a busy-clear written then is ignored and the busy bit stays set.
- R10: `spm_irq` equals interrupt enable AND `gie` AND NOT operation enable.
- R11: A start while lock-set is armed completes at once. `op_done` is high in the start cycle, bits 4..0 clear on the next cycle, and neither busy nor halt changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| gie | input | 1 | Global interrupt enable |
| op_start | input | 1 | Start the armed operation |
| op_addr | input | AW | Target address sampled at start |
| rd_addr | input | AW | Address of the current program-memory read |
| rww_rd_block | output | 1 | Read of the busy read-while-write region must be blocked |
| cpu_halt | output | 1 | CPU halted during a no-read-while-write operation |
| spm_irq | output | 1 | Ready interrupt request |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that `op_start` is a clean synchronous pulse. They also take for granted that the busy bit changes only at a start or as a result of the sequencer, so a rise of busy is always preceded by a start. The stimulus is driven on the falling edge and held across the rising edge. It mixes directed sequences with random writes, starts and read addresses. Among these are starts with nothing armed, arming writes while an operation runs, and read addresses on both sides of the boundary, all of which are legal inputs the design must tolerate.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } sp_state_e;

    // positions inside the 4-bit command field (register bits 4..1)
    localparam int CMD_ERASE = 0;
    localparam int CMD_WRITE = 1;
    localparam int CMD_LOCK  = 2;
    localparam int CMD_BCLR  = 3;
    localparam int CMD_W     = 4;
endpackage

// File: rtl/sp_region.sv
module sp_region #(
    parameter int AW        = 16,
    parameter int RWW_LIMIT = 'hE000
) (
    input  logic [AW-1:0] addr,
    output logic          in_rww
);
    localparam logic [AW-1:0] LIMIT = AW'(RWW_LIMIT);

    always_comb begin
        in_rww = (addr < LIMIT);
    end
endmodule

// File: rtl/sp_down_cnt.sv
module sp_down_cnt #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sp_seq.sv
module sp_seq
    import sp_pkg::*;
#(
    parameter int ARM_WIN   = 16,
    parameter int OP_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_ok,
    input  logic              go,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              tgt_rww,
    output sp_state_e         state,
    output logic              fin,
    output logic              set_busy,
    output logic              clr_busy,
    output logic              halt
);
    localparam int MAXC = (ARM_WIN > OP_CYCLES) ? ARM_WIN : OP_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ARM_LOAD = CW'(ARM_WIN - 1);
    localparam logic [CW-1:0] RUN_LOAD = CW'(OP_CYCLES - 1);

    sp_state_e     state_q, state_d;
    logic          nrww_q;
    logic          cnt_zero;
    logic          cnt_load, cnt_dec;
    logic [CW-1:0] cnt_val;
    logic          long_cmd;

    assign long_cmd = cmd[CMD_ERASE] | cmd[CMD_WRITE];

    sp_down_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            nrww_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ARMED && go && long_cmd) begin
                nrww_q <= ~tgt_rww;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm_ok) state_d = ST_ARMED;
            ST_ARMED: begin
                if (go)            state_d = long_cmd ? ST_RUN : ST_IDLE;
                else if (cnt_zero) state_d = ST_IDLE;
            end
            ST_RUN:   if (cnt_zero) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fin      = 1'b0;
        set_busy = 1'b0;
        clr_busy = 1'b0;
        halt     = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = ARM_LOAD;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_ok) cnt_load = 1'b1;
            end
            ST_ARMED: begin
                if (go) begin
                    if (long_cmd) begin
                        cnt_load = 1'b1;
                        cnt_val  = RUN_LOAD;
                        set_busy = tgt_rww;
                    end else begin
                        fin      = 1'b1;
                        clr_busy = cmd[CMD_BCLR];
                    end
                end else begin
                    cnt_dec = 1'b1;
                    fin     = cnt_zero;
                end
            end
            ST_RUN: begin
                cnt_dec = 1'b1;
                fin     = cnt_zero;
                halt    = nrww_q;
            end
            default: ;
        endcase
    end

    assign state = state_q;

    // R4: an unstarted arming window always ends in IDLE
    assert_arm_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && cnt_zero && !go) |=> (state_q == ST_IDLE));

    // R6: the halt never lasts beyond the run state
    assert_halt_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && cnt_zero) |=> !halt);
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
    import sp_pkg::*;
#(
    parameter int AW        = 16,
    parameter int RWW_LIMIT = 'hE000,
    parameter int ARM_WIN   = 16,
    parameter int OP_CYCLES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_we,
    input  logic [7:0]    csr_wdata,
    output logic [7:0]    csr_rdata,
    input  logic          gie,
    input  logic          op_start,
    input  logic [AW-1:0] op_addr,
    input  logic [AW-1:0] rd_addr,
    output logic          rww_rd_block,
    output logic          cpu_halt,
    output logic          spm_irq,
    output logic          op_done
);
    logic             ie_q, busy_q, en_q;
    logic [CMD_W-1:0] cmd_q;
    logic [CMD_W-1:0] wr_cmd;
    logic             arm_ok;
    logic             tgt_rww, rd_rww;
    logic             fin, set_busy, clr_busy, halt;
    sp_state_e        state;
    logic             unused_ro_bits;

    assign unused_ro_bits = ^csr_wdata[6:5];
    assign wr_cmd = csr_wdata[4:1];
    assign arm_ok = csr_we && (state == ST_IDLE) && csr_wdata[0] && $onehot(wr_cmd);

    sp_region #(.AW(AW), .RWW_LIMIT(RWW_LIMIT)) u_tgt_region (
        .addr   (op_addr),
        .in_rww (tgt_rww)
    );

    sp_region #(.AW(AW), .RWW_LIMIT(RWW_LIMIT)) u_rd_region (
        .addr   (rd_addr),
        .in_rww (rd_rww)
    );

    sp_seq #(.ARM_WIN(ARM_WIN), .OP_CYCLES(OP_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_ok   (arm_ok),
        .go       (op_start),
        .cmd      (cmd_q),
        .tgt_rww  (tgt_rww),
        .state    (state),
        .fin      (fin),
        .set_busy (set_busy),
        .clr_busy (clr_busy),
        .halt     (halt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            busy_q <= 1'b0;
            en_q   <= 1'b0;
            cmd_q  <= '0;
        end else begin
            if (csr_we) ie_q <= csr_wdata[7];
            if (arm_ok) begin
                en_q  <= 1'b1;
                cmd_q <= wr_cmd;
            end else if (fin) begin
                en_q  <= 1'b0;
                cmd_q <= '0;
            end
            if (set_busy)      busy_q <= 1'b1;
            else if (clr_busy) busy_q <= 1'b0;
        end
    end

    assign csr_rdata    = {ie_q, busy_q, 1'b0, cmd_q, en_q};
    assign rww_rd_block = busy_q & rd_rww;
    assign cpu_halt     = halt;
    assign spm_irq      = ie_q & gie & ~en_q;
    assign op_done      = fin;

    // R5: busy only rises as a result of a start
    assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(op_start));

    // R8: busy only falls through a started busy-clear command
    assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(op_start && cmd_q[CMD_BCLR]));

    // R3: enable only rises on a write that carries bit 0
    assert_en_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> $past(csr_we && csr_wdata[0]));

    // R9: command field is frozen while running until completion
    assert_run_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !fin) |=> $stable(cmd_q) && en_q);

    // R6: busy does not move while the CPU is halted
    assert_halt_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && $past(cpu_halt)) |-> $stable(busy_q));
endmodule

// File: tb/sim_selfprog_ctrl.sv
module sim_selfprog_ctrl;
    localparam int AW  = 16;
    localparam int LIM = 'hE000;
    localparam int ARM = 6;
    localparam int OPC = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 1'b0;
    logic [7:0]    csr_wdata = '0;
    logic [7:0]    csr_rdata;
    logic          gie = 1'b0;
    logic          op_start = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          rww_rd_block, cpu_halt, spm_irq, op_done;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // behavioural reference state
    int m_st = 0;          // 0 idle, 1 armed, 2 running
    int m_left = 0;
    int m_ie = 0, m_busy = 0, m_en = 0, m_cmd = 0, m_far = 0;

    always #4 clk = ~clk;   // 125 MHz

    selfprog_ctrl #(.AW(AW), .RWW_LIMIT(LIM), .ARM_WIN(ARM), .OP_CYCLES(OPC)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .gie(gie), .op_start(op_start), .op_addr(op_addr),
        .rd_addr(rd_addr), .rww_rd_block(rww_rd_block), .cpu_halt(cpu_halt),
        .spm_irq(spm_irq), .op_done(op_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int popc4(input int v);
        int n = 0;
        for (int i = 0; i < 4; i++) n += (v >> i) & 1;
        return n;
    endfunction

    task automatic compare_all();
        int e_rd, e_halt, e_irq, e_blk, e_done;
        e_rd   = (m_ie << 7) | (m_busy << 6) | (m_cmd << 1) | m_en;
        e_halt = (m_st == 2 && m_far == 1) ? 1 : 0;
        e_irq  = (m_ie == 1 && gie && m_en == 0) ? 1 : 0;
        e_blk  = (m_busy == 1 && rd_addr < LIM) ? 1 : 0;
        e_done = ((m_st == 2 && m_left == 0) ||
                  (m_st == 1 && !op_start && m_left == 0) ||
                  (m_st == 1 && op_start && (m_cmd & 3) == 0)) ? 1 : 0;
        chk("R2 R3 R4 R5 R8 R9 R11 csr_rdata", int'(csr_rdata), e_rd);
        chk("R6 cpu_halt", int'(cpu_halt), e_halt);
        chk("R10 spm_irq", int'(spm_irq), e_irq);
        chk("R7 rww_rd_block", int'(rww_rd_block), e_blk);
        chk("R5 R11 op_done", int'(op_done), e_done);
    endtask

    task automatic model_edge();
        if (csr_we) m_ie = csr_wdata[7];
        case (m_st)
            0: if (csr_we && csr_wdata[0] && popc4(int'(csr_wdata[4:1])) == 1) begin
                   m_st = 1; m_en = 1; m_cmd = int'(csr_wdata[4:1]); m_left = ARM - 1;
               end
            1: if (op_start) begin
                   if ((m_cmd & 3) != 0) begin
                       m_st = 2; m_left = OPC - 1;
                       m_far = (op_addr >= LIM) ? 1 : 0;
                       if (m_far == 0) m_busy = 1;
                   end else begin
                       if ((m_cmd & 8) != 0) m_busy = 0;
                       m_st = 0; m_en = 0; m_cmd = 0;
                   end
               end else if (m_left == 0) begin
                   m_st = 0; m_en = 0; m_cmd = 0;
               end else m_left--;
            default: if (m_left == 0) begin
                   m_st = 0; m_en = 0; m_cmd = 0;
               end else m_left--;
        endcase
    endtask

    // called just after a falling edge with inputs already set
    task automatic step();
        #2;
        compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        csr_we = 1'b0;
        op_start = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        csr_we = 1'b1; csr_wdata = d; step();
    endtask

    task automatic go(input int a);
        op_start = 1'b1; op_addr = AW'(a); step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog R1..: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk);
        #2;
        chk("R1 reset csr_rdata", int'(csr_rdata), 0);
        chk("R1 reset cpu_halt", int'(cpu_halt), 0);
        chk("R1 reset spm_irq", int'(spm_irq), 0);
        chk("R1 reset op_done", int'(op_done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        gie = 1'b1;
        step();

        wr(8'h80);              // R10: irq with ie set, en clear
        wr(8'hE0);              // R2: read-only bits ignored
        wr(8'h87);              // R3: two command bits, no arm
        wr(8'h81);              // R3: no command bit, no arm
        wr(8'h83); idle(ARM + 2);   // R4: arm erase, window expiry
        wr(8'h85); idle(2); go('h1000);   // R5: write into RWW region
        rd_addr = 16'h0200; step();
        wr(8'h91);              // R9: busy-clear during run ignored
        rd_addr = 16'hF000; idle(OPC + 2);
        rd_addr = 16'h0010; idle(2);     // R7: still blocked after done
        wr(8'h83); go('hF100);   // R6: erase in NRWW region halts
        idle(OPC + 2);
        wr(8'h89); go('h0000);   // R11: lock-set completes at once
        gie = 1'b0; idle(2);
        wr(8'h91); go('h0000);   // R8: busy-clear after finish
        idle(3);
        wr(8'h85); go('hDFFF);   // R5: boundary-1 is RWW
        idle(OPC + 1);
        wr(8'h83); go('hE000);   // R6: boundary is NRWW
        idle(OPC + 1);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            gie = r[0];
            rd_addr = r[1] ? 16'h1234 : 16'hE800;
            if (r[4:2] == 3'd0) begin
                csr_we = 1'b1;
                csr_wdata = {r[5], r[6], r[7], r[11:8] & (r[12] ? 4'hF : (4'h1 << r[14:13])), 1'b1};
            end
            if (r[17:15] == 3'd0) begin
                op_start = 1'b1;
                op_addr = r[18] ? 16'h0400 : 16'hF400;
            end
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule